// File: doc/BRIEF.md
# Nanosecond Timestamp Counter with Drift Trim

This block keeps a 32-bit time value in nanoseconds for stamping network frames. On every enabled tick of the timestamp clock it adds a programmable step equal to that clock's period. A second counter counts ticks and, each time it reaches a programmed limit, makes that one tick add an alternate step instead. Software uses this to pull the average rate up or down and cancel oscillator drift.

The time can wrap at a programmed period, which yields a periodic event that may raise the interrupt flag and pulse an output pin. A one-shot offset comparison raises a single event when the time passes a programmed value, and it can optionally force the time back to zero. Software can restart the time, load it directly, or capture it into a readable register. All control goes through a small word-addressed register port. The current time is also driven on a port for the frame stamping logic.

Top module: `tstamp_timer`

## Requirements
- R1: After reset `timeNow`, `eventPin`, `timerIrq` and every register read are zero.
- R2: When CTRL bit0 (run) is 1 and `tickIn` is 1 at a clock edge, the time grows by STEP[6:0] (address 5). Without both, the time holds.
- R3: A nonzero TRIM value (address 4, 31 bits) N makes every Nth running tick since the last restart add STEP[14:8] in place of STEP[6:0]. N = 0 turns the trim off.
- R4: With a nonzero PERIOD (address 3), a running tick whose sum reaches PERIOD or more stores the sum minus PERIOD and produces a periodic event. PERIOD = 0 never wraps.
- R5: STATUS bit0 (address 6) is set by a periodic event when CTRL bit3 is 1, and by any offset event. It stays set until a write to address 6 with bit0 = 1, and `timerIrq` mirrors it. A set in the same cycle wins over the clear.
- R6: When CTRL bit4 is 1, `eventPin` is high for the clock cycle that follows each periodic event tick.
- R7: When CTRL bit1 (arm) is 1, a running tick with old time below OFFSET (address 2) and sum at or above OFFSET produces one offset event, and arm reads back 0 afterwards.
- R8: When CTRL bit2 is 1, the offset event stores zero as the new time instead of the sum.
- R9: Writing CTRL with bit5 = 1 zeroes the time and the trim counter at that edge. This overrides any tick, and bit5 always reads 0.
- R10: Writing CTRL with bit6 = 1 copies the time held before that edge into the value register, which address 1 reads. Writing address 1 loads the time directly and drops a tick in the same cycle. Bit6 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | One-cycle tick of the timestamp clock |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| timeNow | output | 32 | Current time value in ns |
| eventPin | output | 1 | External periodic event pulse |
| timerIrq | output | 1 | Sticky timer event flag |

## Verification
The time is driven with steady ticks, with gapped ticks, and with ticks while run is off, so that a missing hold can be told apart from a miscounted step. Trim counts of zero and small nonzero values show whether the alternate step lands on exactly the Nth tick. Periods and offsets are placed so that a sum lands on the limit exactly and so that it steps over the limit, which separates an off-by-one compare from a correct one. A long stretch of mixed random ticks, writes, restarts and captures is then checked every cycle against a behavioural model.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_VALUE  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_OFFSET = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_PERIOD = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_TRIM   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_STEP   = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd6;
  localparam int CTL_RUN = 0;
  localparam int CTL_ARM = 1;
  localparam int CTL_ZERO = 2;
  localparam int CTL_PEREN = 3;
  localparam int CTL_PINEN = 4;
  localparam int CTL_RESTART = 5;
  localparam int CTL_CAPTURE = 6;
  localparam int TRIM_STEP_LSB = 8;

  typedef struct packed {
    logic restart;
    logic capture;
    logic load;
  } strobe_t;
endpackage

// File: rtl/tstamp_datapath.sv
module tstamp_datapath
  import tstamp_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int INC_W  = 7,
  parameter int CORR_W = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              run,
  input  strobe_t           stb,
  input  logic [TIME_W-1:0] loadVal,
  input  logic [INC_W-1:0]  incVal,
  input  logic [INC_W-1:0]  corrIncVal,
  input  logic [CORR_W-1:0] corrLim,
  input  logic [TIME_W-1:0] periodVal,
  input  logic [TIME_W-1:0] offsetVal,
  input  logic              offArm,
  input  logic              offZero,
  output logic [TIME_W-1:0] timeQ,
  output logic [TIME_W-1:0] capQ,
  output logic              perEvt,
  output logic              offEvt
);
  localparam int SUM_W = TIME_W + 1;

  logic [CORR_W-1:0] corrCnt;
  logic              corrWrap;
  logic [INC_W-1:0]  stepVal;
  logic [SUM_W-1:0]  rawSum;
  logic [SUM_W-1:0]  wrapSum;
  logic              periodHit;
  logic              offHit;
  logic              tickQual;
  logic              tickUsed;

  assign tickQual = run && tickIn;
  assign tickUsed = tickQual && !stb.restart && !stb.load;

  assign corrWrap = (corrLim != '0) &&
                    (({1'b0, corrCnt} + 1'b1) == {1'b0, corrLim});
  assign stepVal  = corrWrap ? corrIncVal : incVal;
  assign rawSum   = {1'b0, timeQ} + {{(SUM_W-INC_W){1'b0}}, stepVal};

  assign periodHit = (periodVal != '0) && (rawSum >= {1'b0, periodVal});
  assign wrapSum   = periodHit ? (rawSum - {1'b0, periodVal}) : rawSum;
  assign offHit    = offArm && (timeQ < offsetVal) && (rawSum >= {1'b0, offsetVal});

  assign perEvt = tickUsed && periodHit;
  assign offEvt = tickUsed && offHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeQ   <= '0;
      corrCnt <= '0;
    end else if (stb.restart) begin
      timeQ   <= '0;
      corrCnt <= '0;
    end else if (stb.load) begin
      timeQ   <= loadVal;
    end else if (tickQual) begin
      timeQ   <= (offHit && offZero) ? '0 : wrapSum[TIME_W-1:0];
      if (corrWrap || corrLim == '0) corrCnt <= '0;
      else                           corrCnt <= corrCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            capQ <= '0;
    else if (stb.capture) capQ <= timeQ;
  end

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickQual && !stb.restart && !stb.load) |=> (timeQ == $past(timeQ)));

  // R9
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> (timeQ == '0));

  // R10
  capture_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (capQ == $past(timeQ)));
endmodule

// File: rtl/tstamp_ctrl.sv
module tstamp_ctrl
  import tstamp_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int INC_W  = 7,
  parameter int CORR_W = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [TIME_W-1:0] regWrData,
  output logic [TIME_W-1:0] regRdData,
  input  logic              perEvt,
  input  logic              offEvt,
  input  logic [TIME_W-1:0] capVal,
  output strobe_t           stb,
  output logic              run,
  output logic [INC_W-1:0]  incVal,
  output logic [INC_W-1:0]  corrIncVal,
  output logic [CORR_W-1:0] corrLim,
  output logic [TIME_W-1:0] periodVal,
  output logic [TIME_W-1:0] offsetVal,
  output logic              offArm,
  output logic              offZero,
  output logic              eventPin,
  output logic              timerIrq
);
  logic perEn, pinEn, flagQ, wrCtrl, flagClr;

  assign wrCtrl  = regWr && regAddr == ADR_CTRL;
  assign flagClr = regWr && regAddr == ADR_STATUS && regWrData[0];

  assign stb.restart = wrCtrl && regWrData[CTL_RESTART];
  assign stb.capture = wrCtrl && regWrData[CTL_CAPTURE];
  assign stb.load    = regWr && regAddr == ADR_VALUE;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run <= 1'b0; offArm <= 1'b0; offZero <= 1'b0; perEn <= 1'b0; pinEn <= 1'b0;
      incVal <= '0; corrIncVal <= '0; corrLim <= '0;
      periodVal <= '0; offsetVal <= '0;
    end else begin
      if (offEvt)      offArm <= 1'b0;
      else if (wrCtrl) offArm <= regWrData[CTL_ARM];
      if (wrCtrl) begin
        run     <= regWrData[CTL_RUN];
        offZero <= regWrData[CTL_ZERO];
        perEn   <= regWrData[CTL_PEREN];
        pinEn   <= regWrData[CTL_PINEN];
      end
      if (regWr && regAddr == ADR_OFFSET) offsetVal <= regWrData;
      if (regWr && regAddr == ADR_PERIOD) periodVal <= regWrData;
      if (regWr && regAddr == ADR_TRIM)   corrLim   <= regWrData[CORR_W-1:0];
      if (regWr && regAddr == ADR_STEP) begin
        incVal     <= regWrData[INC_W-1:0];
        corrIncVal <= regWrData[TRIM_STEP_LSB +: INC_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ    <= 1'b0;
      eventPin <= 1'b0;
    end else begin
      flagQ    <= (flagQ && !flagClr) || (perEvt && perEn) || offEvt;
      eventPin <= perEvt && pinEn;
    end
  end
  assign timerIrq = flagQ;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADR_CTRL: begin
        regRdData[CTL_RUN]   = run;
        regRdData[CTL_ARM]   = offArm;
        regRdData[CTL_ZERO]  = offZero;
        regRdData[CTL_PEREN] = perEn;
        regRdData[CTL_PINEN] = pinEn;
      end
      ADR_VALUE:  regRdData = capVal;
      ADR_OFFSET: regRdData = offsetVal;
      ADR_PERIOD: regRdData = periodVal;
      ADR_TRIM:   regRdData[CORR_W-1:0] = corrLim;
      ADR_STEP: begin
        regRdData[INC_W-1:0]             = incVal;
        regRdData[TRIM_STEP_LSB +: INC_W] = corrIncVal;
      end
      ADR_STATUS: regRdData[0] = flagQ;
      default:    regRdData = '0;
    endcase
  end

  // R7
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    offEvt |=> !offArm);

  // R5
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timerIrq && !flagClr) |=> timerIrq);

  // R6
  pin_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    eventPin |-> $past(pinEn && perEvt));
endmodule

// File: rtl/tstamp_timer.sv
module tstamp_timer
  import tstamp_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int INC_W  = 7,
  parameter int CORR_W = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [TIME_W-1:0] regWrData,
  output logic [TIME_W-1:0] regRdData,
  output logic [TIME_W-1:0] timeNow,
  output logic              eventPin,
  output logic              timerIrq
);
  strobe_t           stb;
  logic              run, offArm, offZero, perEvt, offEvt;
  logic [INC_W-1:0]  incVal, corrIncVal;
  logic [CORR_W-1:0] corrLim;
  logic [TIME_W-1:0] periodVal, offsetVal, capVal;

  tstamp_ctrl #(.TIME_W(TIME_W), .INC_W(INC_W), .CORR_W(CORR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .perEvt(perEvt), .offEvt(offEvt), .capVal(capVal), .stb(stb),
    .run(run), .incVal(incVal), .corrIncVal(corrIncVal), .corrLim(corrLim),
    .periodVal(periodVal), .offsetVal(offsetVal), .offArm(offArm),
    .offZero(offZero), .eventPin(eventPin), .timerIrq(timerIrq)
  );

  tstamp_datapath #(.TIME_W(TIME_W), .INC_W(INC_W), .CORR_W(CORR_W)) u_dp (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .run(run), .stb(stb),
    .loadVal(regWrData), .incVal(incVal), .corrIncVal(corrIncVal),
    .corrLim(corrLim), .periodVal(periodVal), .offsetVal(offsetVal),
    .offArm(offArm), .offZero(offZero), .timeQ(timeNow), .capQ(capVal),
    .perEvt(perEvt), .offEvt(offEvt)
  );
endmodule

// File: tb/tstamp_timer_tb.sv
module tstamp_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData, timeNow;
  logic        eventPin, timerIrq;

  int total = 0;
  int bad = 0;
  bit chkOn = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tstamp_timer u_dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .timeNow(timeNow),
    .eventPin(eventPin), .timerIrq(timerIrq)
  );

  // behavioural reference state
  longint mTime, mCap, mOff, mPer, mLim, mCnt, mInc, mCInc;
  bit mRun, mArm, mZero, mPerEn, mPinEn, mFlag, mPin;

  always @(posedge clk) begin
    if (!rstN) begin
      mTime = 0; mCap = 0; mOff = 0; mPer = 0; mLim = 0; mCnt = 0; mInc = 0; mCInc = 0;
      mRun = 0; mArm = 0; mZero = 0; mPerEn = 0; mPinEn = 0; mFlag = 0; mPin = 0;
    end else begin
      bit doRst, doCap, doLd, tq, trimNow, pHit, oHit, evP, evO, clr;
      longint sum, nxt;
      doRst = regWr && regAddr == 0 && regWrData[5];
      doCap = regWr && regAddr == 0 && regWrData[6];
      doLd  = regWr && regAddr == 1;
      clr   = regWr && regAddr == 6 && regWrData[0];
      tq = mRun && tickIn;
      trimNow = (mLim != 0) && (mCnt + 1 == mLim);
      sum = mTime + (trimNow ? mCInc : mInc);
      pHit = (mPer != 0) && (sum >= mPer);
      nxt = pHit ? (sum - mPer) : sum;
      nxt = nxt & 64'hFFFF_FFFF;
      oHit = mArm && (mTime < mOff) && (sum >= mOff);
      evP = tq && pHit && !doRst && !doLd;
      evO = tq && oHit && !doRst && !doLd;
      if (doCap) mCap = mTime;
      if (doRst) begin mTime = 0; mCnt = 0; end
      else if (doLd) mTime = regWrData;
      else if (tq) begin
        mTime = (oHit && mZero) ? 0 : nxt;
        mCnt = (trimNow || mLim == 0) ? 0 : mCnt + 1;
      end
      mPin = evP && mPinEn;
      mFlag = (mFlag && !clr) || (evP && mPerEn) || evO;
      if (evO) mArm = 0;
      else if (regWr && regAddr == 0) mArm = regWrData[1];
      if (regWr && regAddr == 0) begin
        mRun = regWrData[0]; mZero = regWrData[2]; mPerEn = regWrData[3]; mPinEn = regWrData[4];
      end
      if (regWr && regAddr == 2) mOff = regWrData;
      if (regWr && regAddr == 3) mPer = regWrData;
      if (regWr && regAddr == 4) mLim = regWrData[30:0];
      if (regWr && regAddr == 5) begin mInc = regWrData[6:0]; mCInc = regWrData[14:8]; end
    end
  end

  function automatic longint modelRead(input logic [2:0] a);
    case (a)
      3'd0: return {mPinEn, mPerEn, mZero, mArm, mRun};
      3'd1: return mCap;
      3'd2: return mOff;
      3'd3: return mPer;
      3'd4: return mLim;
      3'd5: return (mCInc << 8) | mInc;
      3'd6: return mFlag;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (chkOn) begin
    chk("R2 time vs model", timeNow, mTime);
    chk("R6 pin vs model", eventPin, mPin);
    chk("R5 irq vs model", timerIrq, mFlag);
    chk("R10 read vs model", regRdData, modelRead(regAddr));
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #2;
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2; tickIn = 1'b1;
      @(posedge clk); #1; tickIn = 1'b0;
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); #3; regAddr = a; #1; v = regRdData;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 time", timeNow, 0);
    chk("R1 pin", eventPin, 0);
    chk("R1 irq", timerIrq, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk("R1 read", v, 0);
    end
    chkOn = 1;

    // R2 hold when not running, then step
    wr(5, 32'h0000_0D0A);          // step 10, trim step 13
    tick(3);
    @(negedge clk); chk("R2 idle hold", timeNow, 0);
    wr(0, 32'h21);                 // run + restart
    tick(2);
    @(negedge clk); chk("R2 step", timeNow, 20);

    // R3 trim every third tick
    wr(4, 3);
    wr(0, 32'h21);
    tick(6);
    @(negedge clk); chk("R3 trim", timeNow, 66);
    wr(4, 0);

    // R4/R5/R6 period wrap
    wr(5, 30);
    wr(3, 100);
    wr(0, 32'h39);                 // run, perEn, pinEn, restart
    tick(4);
    @(negedge clk);
    chk("R4 wrap", timeNow, 20);
    chk("R6 pin high", eventPin, 1);
    chk("R5 flag set", timerIrq, 1);
    @(negedge clk);
    chk("R6 pin one cycle", eventPin, 0);
    wr(6, 1);
    @(negedge clk); chk("R5 flag cleared", timerIrq, 0);
    wr(3, 0);

    // R7 offset one-shot
    wr(5, 10);
    wr(2, 25);
    wr(0, 32'h23);                 // run, arm, restart
    tick(3);
    @(negedge clk);
    chk("R7 offset time", timeNow, 30);
    chk("R7 offset flag", timerIrq, 1);
    rd(0, v); chk("R7 arm cleared", v[1], 0);
    wr(6, 1);
    // R8 offset zeroes time
    wr(0, 32'h27);
    tick(3);
    @(negedge clk);
    chk("R8 zeroed", timeNow, 0);
    chk("R8 flag", timerIrq, 1);
    wr(6, 1);

    // R9 restart and R10 capture/load
    tick(4);
    wr(0, 32'h41);                 // run + capture
    rd(1, v); chk("R10 capture", v, 40);
    rd(0, v); chk("R9 R10 self clear", v[6:5], 0);
    wr(0, 32'h21);
    @(negedge clk); chk("R9 restart", timeNow, 0);
    wr(1, 32'd1234);
    @(negedge clk); chk("R10 load", timeNow, 1234);

    // mixed traffic, model compared every cycle
    wr(3, 5000); wr(4, 7); wr(5, 32'h0000_1109);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 40;
      @(negedge clk); #2;
      tickIn = ($urandom % 4) != 0;
      regAddr = 3'($urandom % 8);
      if (r == 0) begin regWr = 1; regAddr = 0; regWrData = 32'($urandom % 128) | 1; end
      else if (r == 1) begin regWr = 1; regAddr = 2; regWrData = timeNow + 32'($urandom % 200); end
      else if (r == 2) begin regWr = 1; regAddr = 6; regWrData = 1; end
      else if (r == 3) begin regWr = 1; regAddr = 4; regWrData = 32'($urandom % 6); end
      @(posedge clk); #1;
      regWr = 0; tickIn = 0;
    end
    @(negedge clk);
    chkOn = 0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule